// File: doc/BRIEF.md
# Column-Streaming Matrix-Vector Accumulator

This block evaluates y = alpha*A*x + beta*y for a matrix of ROWS rows and COLS columns (32 by 32 by default) in signed fixed point. A start strobe captures the scalars alpha and beta and the initial y vector. One cycle then scales every row of y by beta at once. After that the matrix arrives one column at a time, each with its x element, through a valid/ready handshake. Columns are consumed in order 0 to COLS-1. For each column, every row accumulator adds its own term in the same cycle, so no row ever waits on another row.

The product alpha*x[j] is formed once per column in a register stage and shared by all row multipliers. Inputs are 16-bit values with 8 fractional bits. Accumulators are 32-bit with the same 8 fractional bits. Every product is shifted right arithmetically by the fractional width, which truncates toward minus infinity. Accumulators saturate instead of wrapping.

The controller has five states. IDLE goes to SCALE on start. SCALE goes to STREAM after one cycle. STREAM goes to DRAIN when the last column is accepted. DRAIN goes to FINISH after one cycle, and FINISH returns to IDLE after one cycle. A synchronous reset returns the controller to IDLE from any state.

Top module: `mv_col_accum`

## Requirements
- R1: While rst is high at a clock edge, the block returns to idle: after that edge every y_out row is 0, col_ready is 0 and done is 0.
- R2: On a start edge in idle, y_init, alpha and beta are captured, and changing those inputs later in the run has no effect. After the next edge every row holds sat32((beta*y_init[i]) >>> 8). col_ready is 0 during this scaling cycle.
- R3: For each accepted column j, in order from 0 to COLS-1, every row updates y[i] = sat32(y[i] + ((((alpha*x[j]) >>> 8) * A[i][j]) >>> 8)). Each row uses only its own previous value, so the final vector equals a row-major reference evaluation. Row i of col_data is bits [16*i +: 16], row i of y_init is bits [16*i +: 16], and row i of y_out is bits [32*i +: 32], all two's complement.
- R4: A column is consumed only in a cycle where col_valid and col_ready are both 1. col_ready is 1 only while columns are still expected, so it is 0 after the last column is accepted. Cycles with col_valid at 0 consume nothing.
- R5: An accumulator that would exceed the 32-bit signed range clamps to 2147483647 or to -2147483648.
- R6: done is 1 for exactly one cycle, the second cycle after the cycle in which the last column was accepted, and by then y_out holds the final result.
- R7: After done, y_out holds its value until the next accepted start, whatever col_valid, x_elem, col_data, alpha, beta and y_init do.
- R8: A start strobe that arrives while a run is in progress is ignored. The run's result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run when the block is idle |
| alpha | input | 16 | Matrix-term scalar, signed, 8 fractional bits |
| beta | input | 16 | Scalar applied to the initial y, signed, 8 fractional bits |
| y_init | input | ROWS*16 | Initial y vector, row i at bits [16*i +: 16] |
| col_valid | input | 1 | A column and its x element are presented |
| col_ready | output | 1 | The block accepts a column this cycle |
| x_elem | input | 16 | x element of the presented column |
| col_data | input | ROWS*16 | Presented matrix column, row i at bits [16*i +: 16] |
| y_out | output | ROWS*32 | Accumulated y vector, row i at bits [32*i +: 32] |
| done | output | 1 | One-cycle pulse when the result is final |

## Verification
The assertions assume that start is a single-cycle pulse when issued from idle. They also assume that col_valid, once raised, stays up until the handshake completes, and that reset is synchronous and lasts at least one edge. The bench raises start for exactly one cycle and drives everything at the falling edge. It holds each column until col_ready is seen and pulls col_valid low only between columns, in deliberate gaps. Stray start pulses in the middle of a run and junk data after done are injected on purpose, to show that both are ignored.

// File: rtl/mvc_pkg.sv
package mvc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCALE,
        ST_STREAM,
        ST_DRAIN,
        ST_FINISH
    } mvc_state_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mvc_ctrl.sv
module mvc_ctrl
    import mvc_pkg::*;
#(
    parameter int COLS = 32,
    localparam int CW = idx_width(COLS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          col_valid,
    output logic          launch,
    output logic          scale_en,
    output logic          col_ready,
    output logic          col_fire,
    output logic          done,
    output logic [CW-1:0] col_idx,
    output mvc_state_e    state
);

    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

    mvc_state_e state_q;
    mvc_state_e state_d;
    logic       last_fire;

    assign last_fire = col_fire && (col_idx == LAST_COL);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SCALE;
            ST_SCALE:  state_d = ST_STREAM;
            ST_STREAM: if (last_fire) state_d = ST_DRAIN;
            ST_DRAIN:  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the current state
    always_comb begin
        launch    = 1'b0;
        scale_en  = 1'b0;
        col_ready = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   launch    = start;
            ST_SCALE:  scale_en  = 1'b1;
            ST_STREAM: col_ready = 1'b1;
            ST_DRAIN:  ;
            ST_FINISH: done      = 1'b1;
            default:   ;
        endcase
    end

    assign col_fire = col_ready && col_valid;

    // column position within the run
    always_ff @(posedge clk) begin
        if (rst || launch) begin
            col_idx <= '0;
        end else if (col_fire && !last_fire) begin
            col_idx <= col_idx + 1'b1;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/mvc_stage.sv
module mvc_stage #(
    parameter int ROWS = 32,
    parameter int DW   = 16,
    parameter int FRAC = 8,
    localparam int AXW = 2 * DW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic [DW-1:0]      alpha_q,
    input  logic [DW-1:0]      x_elem,
    input  logic [ROWS*DW-1:0] col_data,
    output logic [AXW-1:0]     ax_q,
    output logic [ROWS*DW-1:0] col_q,
    output logic               stg_v
);

    logic signed [AXW-1:0] ax_full;
    logic signed [AXW-1:0] ax_shift;

    // alpha*x[j], formed once per column for every row
    assign ax_full  = AXW'($signed(alpha_q)) * AXW'($signed(x_elem));
    assign ax_shift = ax_full >>> FRAC;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_v <= 1'b0;
            ax_q  <= '0;
            col_q <= '0;
        end else begin
            stg_v <= fire;
            if (fire) begin
                ax_q  <= ax_shift;
                col_q <= col_data;
            end
        end
    end

endmodule

// File: rtl/mvc_row.sv
module mvc_row #(
    parameter int DW   = 16,
    parameter int AW   = 32,
    parameter int FRAC = 8,
    localparam int AXW = 2 * DW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [DW-1:0]  y_init,
    input  logic           scale_en,
    input  logic [DW-1:0]  beta_q,
    input  logic           acc_en,
    input  logic [AXW-1:0] ax,
    input  logic [DW-1:0]  a_elem,
    output logic [AW-1:0]  acc
);

    localparam int SPW = DW + AW;
    localparam int PW  = AXW + DW;
    localparam int SW  = ((PW > AW) ? PW : AW) + 1;
    localparam logic [AW-1:0] POS_MAX = {1'b0, {(AW-1){1'b1}}};
    localparam logic [AW-1:0] NEG_MAX = {1'b1, {(AW-1){1'b0}}};

    logic signed [AW-1:0]  acc_q;
    logic signed [SPW-1:0] sprod;
    logic signed [SPW-1:0] sshift;
    logic [AW-1:0]         scaled;
    logic signed [PW-1:0]  mprod;
    logic signed [PW-1:0]  term;
    logic signed [SW-1:0]  sum;
    logic [AW-1:0]         summed;

    // beta scaling of the loaded value
    assign sprod  = SPW'($signed(beta_q)) * SPW'(acc_q);
    assign sshift = sprod >>> FRAC;

    always_comb begin
        if (sshift[SPW-1:AW-1] == {(SPW-AW+1){sshift[SPW-1]}}) begin
            scaled = sshift[AW-1:0];
        end else begin
            scaled = sshift[SPW-1] ? NEG_MAX : POS_MAX;
        end
    end

    // column term and saturating accumulation
    assign mprod = PW'($signed(ax)) * PW'($signed(a_elem));
    assign term  = mprod >>> FRAC;
    assign sum   = SW'(acc_q) + SW'(term);

    always_comb begin
        if (sum[SW-1:AW-1] == {(SW-AW+1){sum[SW-1]}}) begin
            summed = sum[AW-1:0];
        end else begin
            summed = sum[SW-1] ? NEG_MAX : POS_MAX;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (load) begin
            acc_q <= AW'($signed(y_init));
        end else if (scale_en) begin
            acc_q <= scaled;
        end else if (acc_en) begin
            acc_q <= summed;
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/mv_col_accum.sv
module mv_col_accum
    import mvc_pkg::*;
#(
    parameter int ROWS = 32,
    parameter int COLS = 32,
    parameter int DW   = 16,
    parameter int AW   = 32,
    parameter int FRAC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [DW-1:0]      alpha,
    input  logic [DW-1:0]      beta,
    input  logic [ROWS*DW-1:0] y_init,
    input  logic               col_valid,
    output logic               col_ready,
    input  logic [DW-1:0]      x_elem,
    input  logic [ROWS*DW-1:0] col_data,
    output logic [ROWS*AW-1:0] y_out,
    output logic               done
);

    localparam int CW  = idx_width(COLS);
    localparam int AXW = 2 * DW;

    logic               launch;
    logic               scale_en;
    logic               col_fire;
    logic [CW-1:0]      col_idx_w;
    mvc_state_e         state_w;
    logic [DW-1:0]      alpha_q;
    logic [DW-1:0]      beta_q;
    logic [AXW-1:0]     ax_q;
    logic [ROWS*DW-1:0] col_q;
    logic               stg_v;

    mvc_ctrl #(.COLS(COLS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .col_valid (col_valid),
        .launch    (launch),
        .scale_en  (scale_en),
        .col_ready (col_ready),
        .col_fire  (col_fire),
        .done      (done),
        .col_idx   (col_idx_w),
        .state     (state_w)
    );

    // scalars captured with the run
    always_ff @(posedge clk) begin
        if (rst) begin
            alpha_q <= '0;
            beta_q  <= '0;
        end else if (launch) begin
            alpha_q <= alpha;
            beta_q  <= beta;
        end
    end

    mvc_stage #(.ROWS(ROWS), .DW(DW), .FRAC(FRAC)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .fire     (col_fire),
        .alpha_q  (alpha_q),
        .x_elem   (x_elem),
        .col_data (col_data),
        .ax_q     (ax_q),
        .col_q    (col_q),
        .stg_v    (stg_v)
    );

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        mvc_row #(.DW(DW), .AW(AW), .FRAC(FRAC)) u_row (
            .clk      (clk),
            .rst      (rst),
            .load     (launch),
            .y_init   (y_init[i*DW +: DW]),
            .scale_en (scale_en),
            .beta_q   (beta_q),
            .acc_en   (stg_v),
            .ax       (ax_q),
            .a_elem   (col_q[i*DW +: DW]),
            .acc      (y_out[i*AW +: AW])
        );
    end

endmodule

// File: rtl/mvc_chk.sv
module mvc_chk
    import mvc_pkg::*;
#(
    parameter int ROWS = 32,
    parameter int AW   = 32,
    parameter int CW   = 5,
    parameter int COLS = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               col_valid,
    input logic               col_ready,
    input logic               done,
    input logic [CW-1:0]      col_idx,
    input mvc_state_e         state,
    input logic [ROWS*AW-1:0] y_out
);

    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_done_after_drain: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN) |=> done);

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start) |=> $stable(y_out));

    a_r2_scale_not_ready: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=> !col_ready);

    a_r4_last_drops_ready: assert property (@(posedge clk) disable iff (rst)
        (col_valid && col_ready && col_idx == LAST_COL) |=> !col_ready);

    a_r4_idle_hold_idx: assert property (@(posedge clk) disable iff (rst)
        (col_ready && !col_valid) |=> $stable(col_idx));

    a_r4_idx_step: assert property (@(posedge clk) disable iff (rst)
        (col_valid && col_ready && col_idx != LAST_COL) |=> (col_idx == $past(col_idx) + 1'b1));

    a_r8_busy_start: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && start) |=> (state != ST_SCALE));

endmodule

bind mv_col_accum mvc_chk #(.ROWS(ROWS), .AW(AW), .CW(CW), .COLS(COLS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .col_valid (col_valid),
    .col_ready (col_ready),
    .done      (done),
    .col_idx   (col_idx_w),
    .state     (state_w),
    .y_out     (y_out)
);

// File: tb/sim_mv_col_accum.sv
module sim_mv_col_accum;

    localparam int ROWS = 32;
    localparam int COLS = 32;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic [15:0]        alpha = '0;
    logic [15:0]        beta = '0;
    logic [ROWS*16-1:0] y_init = '0;
    logic               col_valid = 1'b0;
    logic               col_ready;
    logic [15:0]        x_elem = '0;
    logic [ROWS*16-1:0] col_data = '0;
    logic [ROWS*32-1:0] y_out;
    logic               done;

    always #10 clk = ~clk;

    mv_col_accum u0 (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .alpha     (alpha),
        .beta      (beta),
        .y_init    (y_init),
        .col_valid (col_valid),
        .col_ready (col_ready),
        .x_elem    (x_elem),
        .col_data  (col_data),
        .y_out     (y_out),
        .done      (done)
    );

    int total = 0;
    int fails = 0;
    int cyc = 0;
    bit ended = 1'b0;

    logic signed [15:0] mA [ROWS][COLS];
    logic signed [15:0] vx [COLS];
    logic signed [15:0] vy [ROWS];
    longint             ref_y [ROWS];

    // {alpha, beta, mode, gaps, poke}; modes: 0 full random, 1 small random, 2 all max, 3 negative A
    localparam logic [36:0] CASES [6] = '{
        {16'h0100, 16'h0100, 3'd1, 1'b0, 1'b0},
        {16'hFF80, 16'h0180, 3'd1, 1'b1, 1'b1},
        {16'h0000, 16'hFE00, 3'd0, 1'b0, 1'b0},
        {16'h7FFF, 16'h0100, 3'd2, 1'b0, 1'b0},
        {16'h7FFF, 16'h0100, 3'd3, 1'b1, 1'b0},
        {16'h8000, 16'h8000, 3'd0, 1'b1, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint sat32(input longint v);
        if (v > 64'sd2147483647) return 64'sd2147483647;
        if (v < -64'sd2147483648) return -64'sd2147483648;
        return v;
    endfunction

    function automatic longint row_out(input int i);
        return longint'($signed(y_out[i*32 +: 32]));
    endfunction

    task automatic fill(input int mode);
        for (int i = 0; i < ROWS; i++) begin
            for (int j = 0; j < COLS; j++) begin
                case (mode)
                    0: mA[i][j] = 16'($urandom());
                    1: mA[i][j] = 16'($signed(10'($urandom())));
                    2: mA[i][j] = 16'sh7FFF;
                    default: mA[i][j] = 16'sh8000;
                endcase
            end
            case (mode)
                0: vy[i] = 16'($urandom());
                1: vy[i] = 16'($signed(10'($urandom())));
                2: vy[i] = 16'sh7FFF;
                default: vy[i] = 16'sh0000;
            endcase
        end
        for (int j = 0; j < COLS; j++) begin
            case (mode)
                0: vx[j] = 16'($urandom());
                1: vx[j] = 16'($signed(10'($urandom())));
                default: vx[j] = 16'sh7FFF;
            endcase
        end
    endtask

    // row-major reference: outer loop over rows, inner over columns
    task automatic compute_ref(input logic [15:0] a, input logic [15:0] b);
        longint la, lb, ax, t;
        la = longint'($signed(a));
        lb = longint'($signed(b));
        for (int i = 0; i < ROWS; i++) begin
            ref_y[i] = sat32((lb * longint'(vy[i])) >>> 8);
            for (int j = 0; j < COLS; j++) begin
                ax = (la * longint'(vx[j])) >>> 8;
                t  = (ax * longint'(mA[i][j])) >>> 8;
                ref_y[i] = sat32(ref_y[i] + t);
            end
        end
    endtask

    task automatic present_col(input int j);
        x_elem = vx[j];
        for (int i = 0; i < ROWS; i++) col_data[i*16 +: 16] = mA[i][j];
    endtask

    task automatic launch_run(input logic [15:0] a, input logic [15:0] b, input string req);
        for (int i = 0; i < ROWS; i++) y_init[i*16 +: 16] = vy[i];
        alpha = a;
        beta  = b;
        start = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        alpha  = 16'($urandom());
        beta   = 16'($urandom());
        y_init = {ROWS{16'($urandom())}};
        chk(col_ready == 1'b0, req, "col_ready during scale", longint'(col_ready), 0);
    endtask

    task automatic run_case(input logic [15:0] a, input logic [15:0] b, input bit gaps,
                            input bit poke, input string req);
        launch_run(a, b, req);
        for (int j = 0; j < COLS; j++) begin
            if (gaps && (j % 3 == 1)) begin
                col_valid = 1'b0;
                present_col((j + 5) % COLS);
                @(negedge clk);
                @(negedge clk);
            end
            present_col(j);
            col_valid = 1'b1;
            if (poke && j == 10) begin
                start  = 1'b1;
                y_init = {ROWS{16'h1234}};
            end
            while (!col_ready) @(negedge clk);
            @(negedge clk);
            start = 1'b0;
        end
        col_valid = 1'b0;
        chk(done == 1'b0, "R6", "done in drain cycle", longint'(done), 0);
        chk(col_ready == 1'b0, "R4", "col_ready after last column", longint'(col_ready), 0);
        @(negedge clk);
        chk(done == 1'b1, "R6", "done pulse", longint'(done), 1);
        for (int i = 0; i < ROWS; i++) begin
            chk(row_out(i) == ref_y[i], (poke ? "R8" : req), $sformatf("row %0d", i),
                row_out(i), ref_y[i]);
        end
        @(negedge clk);
        chk(done == 1'b0, "R6", "done after pulse", longint'(done), 0);
    endtask

    task automatic summary;
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            fails++;
            total++;
            $display("FAIL R6 watchdog: actual hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [ROWS*32-1:0] held;
        string req;
        repeat (3) @(negedge clk);
        chk(y_out == '0, "R1", "y_out after reset", longint'(y_out[31:0]), 0);
        chk(col_ready == 1'b0, "R1", "col_ready after reset", longint'(col_ready), 0);
        chk(done == 1'b0, "R1", "done after reset", longint'(done), 0);
        rst = 1'b0;
        @(negedge clk);

        for (int c = 0; c < 6; c++) begin
            logic [15:0] ca, cb;
            ca = CASES[c][36:21];
            cb = CASES[c][20:5];
            fill(int'(CASES[c][4:2]));
            compute_ref(ca, cb);
            if (c == 2) req = "R2";
            else if (c == 3 || c == 4) req = "R5";
            else req = "R3";
            run_case(ca, cb, CASES[c][1], CASES[c][0], req);
            if (c == 3) chk(ref_y[0] == 64'sd2147483647, "R5", "positive clamp reference",
                            ref_y[0], 64'sd2147483647);
            if (c == 4) chk(ref_y[0] == -64'sd2147483648, "R5", "negative clamp reference",
                            ref_y[0], -64'sd2147483648);
        end

        // R7: result holds while junk arrives and no start is given
        held = y_out;
        for (int k = 0; k < 4; k++) begin
            col_valid = 1'b1;
            x_elem    = 16'($urandom());
            col_data  = {ROWS{16'($urandom())}};
            alpha     = 16'($urandom());
            y_init    = {ROWS{16'($urandom())}};
            @(negedge clk);
            chk(y_out == held, "R7", "y_out hold after done", longint'(y_out[31:0]),
                longint'(held[31:0]));
            chk(col_ready == 1'b0, "R4", "col_ready idle", longint'(col_ready), 0);
        end
        col_valid = 1'b0;

        // R1: reset in the middle of a run
        fill(1);
        launch_run(16'h0100, 16'h0100, "R2");
        for (int j = 0; j < 5; j++) begin
            present_col(j);
            col_valid = 1'b1;
            while (!col_ready) @(negedge clk);
            @(negedge clk);
        end
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        col_valid = 1'b0;
        chk(y_out == '0, "R1", "y_out after mid-run reset", longint'(y_out[31:0]), 0);
        chk(col_ready == 1'b0, "R1", "col_ready after mid-run reset", longint'(col_ready), 0);
        chk(done == 1'b0, "R1", "done after mid-run reset", longint'(done), 0);
        @(negedge clk);
        chk(col_ready == 1'b0, "R1", "still idle after reset", longint'(col_ready), 0);

        // recovery run after reset
        fill(0);
        compute_ref(16'h0040, 16'hFF00);
        run_case(16'h0040, 16'hFF00, 1'b1, 1'b0, "R3");

        summary();
        $finish;
    end

endmodule